// File: doc/BRIEF.md
# Data-Processing Execute Unit with Condition Flags

This block is the execute stage of a load-store RISC core for data-processing operations. It takes one operation per handshake. Each operation has a 4-bit operation code, a set-flags bit, a first operand, a second operand that the shifter has already prepared, and that shifter's carry-out. The block computes a 32-bit result and decides whether the destination register is written. It also holds the architectural negative/zero/carry/overflow flags in a register of its own. The arithmetic operations that take a carry-in read that register.

Operations enter over a valid/ready interface and leave over another, each with a single output slot. An operation is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its result appears in the output slot after that edge. The flag register is updated on the same edge. `in_ready` is high when the slot is empty or is being drained in the same cycle, so a consumer that holds `out_ready` high gets one operation per cycle. When `out_ready` is low and the slot is full, the slot keeps its value and no new operation is accepted. Operand shifting, multiply, decode and condition gating belong to other blocks.

Top module: `exec_alu`

## Requirements
- R1: Arithmetic results are 32-bit two's complement, using these opcodes: 0 AND, 1 EOR, 2 SUB (A-B), 3 RSB (B-A), 4 ADD (A+B), 5 ADC (A+B+C), 6 SBC (A-B-1+C), 7 RSC (B-A-1+C), 8 TST, 9 TEQ, 10 CMP, 11 CMN, 12 ORR, 13 MOV, 14 BIC, 15 MVN.
- R2: Logical results are A AND B, A XOR B, A OR B, A AND NOT B (0x11111111 with 0x01100101 gives 0x10011010), B for move, and NOT B for move-not.
- R3: The four compare/test opcodes (8 to 11) present A AND B, A XOR B, A-B and A+B on `out_result` with `out_wr_en` low. Every other opcode raises `out_wr_en`.
- R4: For arithmetic opcodes, C is the adder carry-out, so C=1 on subtraction means no borrow. V is set on signed overflow.
- R5: For logical, move and test opcodes, C takes `in_shift_carry` and V keeps its previous value.
- R6: When flags update, N is result bit 31 and Z is 1 exactly when the result is zero. `flags_o` packs N,Z,C,V in bits 3,2,1,0.
- R7: Flags change only on an accepted operation that has `in_set_flags` high or is a compare/test opcode. Otherwise they hold.
- R8: The carry-using opcodes read the flag register as already updated by the previous accepted operation. A set-flags ADD followed back-to-back by ADC forms a 64-bit sum.
- R9: `in_ready` = !`out_valid` or `out_ready`. While `out_valid` is high and `out_ready` is low, `out_result` and `out_wr_en` stay stable.
- R10: Reset (active-low `rst_n`) clears `out_valid` and all four flags and leaves `in_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted |
| in_op | input | 4 | Operation code |
| in_set_flags | input | 1 | Update flags from this operation |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Shifted second operand |
| in_shift_carry | input | 1 | Carry-out of the operand shifter |
| out_valid | output | 1 | Output slot holds a result |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 32 | Computed value |
| out_wr_en | output | 1 | Destination register is written |
| flags_o | output | 4 | Flag register {N,Z,C,V} |

## Verification
The result, write enable and flags of an accepted operation are due one edge after acceptance. The bench therefore drives each operation at a falling edge and samples the outputs at the next falling edge, once that single register stage has been crossed. The back-to-back carry chain sends two operations on consecutive edges. The stall test holds `out_ready` low for several cycles and checks that the slot does not change and that the waiting operation appears one edge after `out_ready` is raised.

// File: rtl/exec_alu_pkg.sv
package exec_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
    OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
    OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
    OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  localparam int FLAG_W = $bits(nzcv_t);

  // Compare/test opcodes occupy 8..11.
  function automatic logic op_is_probe(input logic [3:0] op);
    return op[3:2] == 2'b10;
  endfunction

  // Opcodes whose carry comes from the shifter.
  function automatic logic op_is_logic(input logic [3:0] op);
    case (op)
      OP_AND, OP_EOR, OP_TST, OP_TEQ,
      OP_ORR, OP_MOV, OP_BIC, OP_MVN: return 1'b1;
      default:                        return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/exec_alu_adder.sv
module exec_alu_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  logic [W:0] wide;

  always_comb begin
    wide = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
    sum  = wide[W-1:0];
    cout = wide[W];
    ovf  = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);
  end
endmodule

// File: rtl/exec_alu_logic.sv
module exec_alu_logic
  import exec_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res
);
  always_comb begin
    case (op)
      OP_AND, OP_TST: res = a & b;
      OP_EOR, OP_TEQ: res = a ^ b;
      OP_ORR:         res = a | b;
      OP_MOV:         res = b;
      OP_BIC:         res = a & ~b;
      OP_MVN:         res = ~b;
      default:        res = '0;
    endcase
  end
endmodule

// File: rtl/exec_alu_flagsel.sv
module exec_alu_flagsel
  import exec_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]   op,
  input  logic         set_flags,
  input  logic [W-1:0] result,
  input  logic         add_cout,
  input  logic         add_ovf,
  input  logic         shift_carry,
  input  nzcv_t        cur,
  output logic         upd,
  output nzcv_t        nxt
);
  logic logic_op;

  always_comb begin
    logic_op = op_is_logic(op);
    upd      = set_flags || op_is_probe(op);
    nxt.n    = result[W-1];
    nxt.z    = (result == '0);
    nxt.c    = logic_op ? shift_carry : add_cout;
    nxt.v    = logic_op ? cur.v : add_ovf;
  end
endmodule

// File: rtl/exec_alu.sv
module exec_alu
  import exec_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [3:0]   in_op,
  input  logic         in_set_flags,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic         in_shift_carry,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_result,
  output logic         out_wr_en,
  output logic [FLAG_W-1:0] flags_o
);
  nzcv_t        flags_q;
  nzcv_t        flags_nxt;
  logic         flags_upd;
  logic         accept;
  logic [W-1:0] add_x, add_y, add_sum, logic_res, result;
  logic         add_cin, add_cout, add_ovf;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign flags_o  = flags_q;

  // Adder operand steering: subtraction is x + ~y + carry-in.
  always_comb begin
    add_x   = in_a;
    add_y   = in_b;
    add_cin = 1'b0;
    case (in_op)
      OP_SUB, OP_CMP: begin add_y = ~in_b; add_cin = 1'b1; end
      OP_RSB:         begin add_x = in_b; add_y = ~in_a; add_cin = 1'b1; end
      OP_ADC:         add_cin = flags_q.c;
      OP_SBC:         begin add_y = ~in_b; add_cin = flags_q.c; end
      OP_RSC:         begin add_x = in_b; add_y = ~in_a; add_cin = flags_q.c; end
      default:        ;
    endcase
  end

  exec_alu_adder #(.W(W)) u_adder (
    .x(add_x), .y(add_y), .cin(add_cin),
    .sum(add_sum), .cout(add_cout), .ovf(add_ovf)
  );

  exec_alu_logic #(.W(W)) u_logic (
    .op(in_op), .a(in_a), .b(in_b), .res(logic_res)
  );

  assign result = op_is_logic(in_op) ? logic_res : add_sum;

  exec_alu_flagsel #(.W(W)) u_flags (
    .op(in_op), .set_flags(in_set_flags), .result(result),
    .add_cout(add_cout), .add_ovf(add_ovf), .shift_carry(in_shift_carry),
    .cur(flags_q), .upd(flags_upd), .nxt(flags_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_wr_en  <= 1'b0;
      flags_q    <= '0;
    end else begin
      if (accept) begin
        out_valid  <= 1'b1;
        out_result <= result;
        out_wr_en  <= !op_is_probe(in_op);
        if (flags_upd) flags_q <= flags_nxt;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/exec_alu_chk.sv
module exec_alu_chk
  import exec_alu_pkg::*;
#(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [3:0]   in_op,
  input logic         in_set_flags,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_result,
  input logic         out_wr_en,
  input logic [FLAG_W-1:0] flags_o
);
  logic take;
  assign take = in_valid && in_ready;

  AST_PROBE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (take && op_is_probe(in_op)) |=> (out_valid && !out_wr_en)); // R3

  AST_OP_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !op_is_probe(in_op)) |=> (out_valid && out_wr_en)); // R3

  AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!take || (!in_set_flags && !op_is_probe(in_op))) |=> $stable(flags_o)); // R7

  AST_LOGIC_KEEPS_V: assert property (@(posedge clk) disable iff (!rst_n)
    (take && op_is_logic(in_op)) |=> (flags_o[0] == $past(flags_o[0]))); // R5

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_wr_en))); // R9

  AST_NO_TAKE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R9
endmodule

bind exec_alu exec_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_set_flags(in_set_flags), .out_valid(out_valid),
  .out_ready(out_ready), .out_result(out_result), .out_wr_en(out_wr_en),
  .flags_o(flags_o)
);

// File: tb/exec_alu_test.sv
module exec_alu_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 18;

  typedef struct packed {
    logic [3:0]  op;
    logic        s;
    logic [31:0] a;
    logic [31:0] b;
    logic        shc;
    logic [31:0] res;
    logic        we;
    logic [3:0]  fl;
  } vec_t;

  // Flags carry over from one row to the next; expected NZCV follows the sequence.
  localparam vec_t VECS [NV] = '{
    '{4'h4, 1'b1, 32'h7FFFFFFF, 32'h00000001, 1'b0, 32'h80000000, 1'b1, 4'b1001}, // R1 R4 R6 ADD overflow
    '{4'h2, 1'b1, 32'h00000005, 32'h00000005, 1'b0, 32'h00000000, 1'b1, 4'b0110}, // R1 R4 SUB zero, no borrow
    '{4'h2, 1'b1, 32'h00000003, 32'h00000005, 1'b0, 32'hFFFFFFFE, 1'b1, 4'b1000}, // R1 R4 SUB borrow
    '{4'h3, 1'b1, 32'h00000003, 32'h00000005, 1'b0, 32'h00000002, 1'b1, 4'b0010}, // R1 RSB
    '{4'hE, 1'b0, 32'h11111111, 32'h01100101, 1'b1, 32'h10011010, 1'b1, 4'b0010}, // R2 R7 BIC no S
    '{4'hF, 1'b1, 32'h12345678, 32'h00000000, 1'b0, 32'hFFFFFFFF, 1'b1, 4'b1000}, // R2 R5 MVN
    '{4'hA, 1'b0, 32'h80000000, 32'h00000001, 1'b0, 32'h7FFFFFFF, 1'b0, 4'b0011}, // R3 R4 CMP overflow
    '{4'h8, 1'b0, 32'h000000F0, 32'h0000000F, 1'b1, 32'h00000000, 1'b0, 4'b0111}, // R3 R5 TST keeps V
    '{4'h5, 1'b1, 32'h00000001, 32'h00000001, 1'b0, 32'h00000003, 1'b1, 4'b0000}, // R1 R8 ADC with C=1
    '{4'h6, 1'b1, 32'h0000000A, 32'h00000003, 1'b0, 32'h00000006, 1'b1, 4'b0010}, // R1 SBC with C=0
    '{4'h7, 1'b1, 32'h00000003, 32'h0000000A, 1'b0, 32'h00000007, 1'b1, 4'b0010}, // R1 RSC with C=1
    '{4'h1, 1'b1, 32'hFF00FF00, 32'hFFFFFFFF, 1'b0, 32'h00FF00FF, 1'b1, 4'b0000}, // R2 EOR
    '{4'hB, 1'b0, 32'hFFFFFFFF, 32'h00000001, 1'b0, 32'h00000000, 1'b0, 4'b0110}, // R3 CMN
    '{4'h9, 1'b0, 32'h80000000, 32'h00000000, 1'b0, 32'h80000000, 1'b0, 4'b1000}, // R3 TEQ
    '{4'hC, 1'b0, 32'h0000000F, 32'h000000F0, 1'b1, 32'h000000FF, 1'b1, 4'b1000}, // R2 R7 ORR no S
    '{4'hD, 1'b1, 32'hDEADBEEF, 32'h00000000, 1'b1, 32'h00000000, 1'b1, 4'b0110}, // R2 R5 R6 MOV
    '{4'h0, 1'b1, 32'hFFFF0000, 32'h8000FFFF, 1'b0, 32'h80000000, 1'b1, 4'b1000}, // R2 AND
    '{4'h4, 1'b0, 32'h00000001, 32'h00000002, 1'b1, 32'h00000003, 1'b1, 4'b1000}  // R7 ADD no S
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = '0;
  logic        in_set_flags = 1'b0;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic        in_shift_carry = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic        out_wr_en;
  logic [3:0]  flags_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exec_alu uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_set_flags(in_set_flags), .in_a(in_a), .in_b(in_b),
    .in_shift_carry(in_shift_carry), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_wr_en(out_wr_en), .flags_o(flags_o)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic drive(input logic [3:0] op, input logic s, input logic [31:0] a,
                       input logic [31:0] b, input logic shc);
    in_op = op; in_set_flags = s; in_a = a; in_b = b; in_shift_carry = shc;
    in_valid = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 out_valid", {31'b0, out_valid}, 32'd0);
    check("R10 flags", {28'b0, flags_o}, 32'd0);
    check("R10 in_ready", {31'b0, in_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].op, VECS[i].s, VECS[i].a, VECS[i].b, VECS[i].shc);
      @(negedge clk);
      in_valid = 1'b0;
      check($sformatf("R1/R2/R3 row %0d result", i), out_result, VECS[i].res);
      check($sformatf("R3 row %0d wr_en", i), {31'b0, out_wr_en}, {31'b0, VECS[i].we});
      check($sformatf("R4-R7 row %0d flags", i), {28'b0, flags_o}, {28'b0, VECS[i].fl});
      check($sformatf("R9 row %0d valid", i), {31'b0, out_valid}, 32'd1);
      @(negedge clk);
    end

    // R8: 64-bit add, ADDS low then ADC high on consecutive edges
    drive(4'h4, 1'b1, 32'hFFFFFFFF, 32'h00000001, 1'b0);
    @(negedge clk);
    check("R8 low word", out_result, 32'h00000000);
    check("R8 low flags", {28'b0, flags_o}, 32'b0110);
    drive(4'h5, 1'b1, 32'h00000000, 32'h00000000, 1'b0);
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 high word", out_result, 32'h00000001);
    check("R8 high flags", {28'b0, flags_o}, 32'b0000);
    @(negedge clk);

    // R9: back-pressure
    out_ready = 1'b0;
    drive(4'h4, 1'b0, 32'd10, 32'd20, 1'b0);
    @(negedge clk);
    check("R9 first result", out_result, 32'd30);
    check("R9 ready low when full", {31'b0, in_ready}, 32'd0);
    drive(4'h4, 1'b1, 32'd1, 32'd1, 1'b0);
    repeat (2) @(negedge clk);
    check("R9 held result", out_result, 32'd30);
    check("R9 held valid", {31'b0, out_valid}, 32'd1);
    check("R7 flags untouched while stalled", {28'b0, flags_o}, 32'd0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 second result", out_result, 32'd2);
    check("R9 second valid", {31'b0, out_valid}, 32'd1);
    @(negedge clk);
    check("R9 slot drained", {31'b0, out_valid}, 32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule